// File: doc/BRIEF.md
# Baud-Rate Sign-Sampled Phase Detector with Lane Vote

This block turns per-symbol data decisions and error-sign samples into a timing-error signal for a clock and data recovery loop. Each parallel word carries one data bit and one error-sign bit for each of several lanes. Lane 0 holds the earliest symbol in the word. The block looks at a window of three consecutive symbols for every lane. It matches the pattern of data and error signs in that window against a fixed set of transition patterns. From the match it reports that the sampling clock is late, early, or that the window carries no timing information.

The two most recent symbols of each word are kept for the next word, so the window of lane 0 (and of lane 1) reaches back across the word boundary. The per-lane results are reduced by a sign-of-sum vote to one ternary value per word. The loop filter downstream consumes that value. Results come out of a register one cycle after the word is accepted. The first word after reset has no history to look back on, so its results are forced to "none".

Top module: `mm_phase_vote`

## Requirements
- R1: With data 0,0,1 in a lane's window (oldest first), error signs one back = 1 and current = 0 give late. Error signs two back = 1 and one back = 0 give early.
- R2: With data 0,1,1, error signs one back = 0 and current = 1 give late. Error signs two back = 0 and one back = 1 give early.
- R3: With data 1,0,0, error signs one back = 0 and current = 1 give late. Error signs two back = 0 and one back = 1 give early.
- R4: With data 1,1,0, error signs one back = 1 and current = 0 give late. Error signs two back = 1, one back = 0 and current = 0 give early. If the current error sign is 1 instead, the lane gives none.
- R5: Every other combination of data window and error signs gives none, including windows 0,1,0 and 1,0,1, and a matching data window whose error signs fit neither rule.
- R6: Lane i's result appears on `out_lane_dir[2*i+1:2*i]`, coded 01 = late (+1), 11 = early (-1), 00 = none. Code 10 is never produced.
- R7: `out_vote` uses the same coding. It is late when late lanes outnumber early lanes, early when early lanes outnumber late lanes, and none when the counts are equal, including when all lanes are none.
- R8: The window of lane i holds the symbols at lanes i-2, i-1 and i, where indices -2 and -1 are lanes LANES-2 and LANES-1 of the previous accepted word.
- R9: While `rst_n` is low, both stored symbols and their error signs are cleared and all outputs read 0. The word accepted first after reset gives vote 00 and all lane codes 00.
- R10: `out_valid` follows `in_valid` with one cycle of delay. While `out_valid` is 0, both result outputs are 0. Inputs offered while `in_valid` is 0 do not change the stored history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is present on `in_data`/`in_err` this cycle |
| in_data | input | LANES | Data decisions; bit 0 is the earliest symbol |
| in_err | input | LANES | Error-sign samples, same lane order |
| out_valid | output | 1 | Results below belong to the word of the previous cycle |
| out_vote | output | 2 | Voted timing direction: 01 late, 11 early, 00 none |
| out_lane_dir | output | 2*LANES | Per-lane timing direction, two bits per lane |

## Verification
Two functions can act on the same word: the carry of history across the word boundary, which feeds lane 0, and the cancellation in the vote. The bench provokes this with a word in which lane 0 goes early only because of the previous word's last two symbols, while lane 3 goes late from the current word alone. Both lane codes are checked, and the vote must read 00. A second case applies the boundary carry on the second word after reset, where lane 0 fires from the first word's tail while the first word's own result was forced to none.

// File: rtl/mmpv_pkg.sv
// Package for the baud-rate phase detector.
// Holds the ternary direction coding and the three-symbol pattern lookup
// that every lane shares. Assumes windows are packed oldest symbol first.
package mmpv_pkg;

    // Two-bit ternary direction: +1 late, -1 early, 0 none.
    typedef enum logic [1:0] {
        DIR_NONE  = 2'b00,
        DIR_LATE  = 2'b01,
        DIR_EARLY = 2'b11
    } dir_e;

    // Pattern lookup. d and e are windows with bit 2 = two symbols back,
    // bit 1 = one symbol back, bit 0 = current symbol.
    function automatic dir_e classify(input logic [2:0] d, input logic [2:0] e);
        dir_e r;
        r = DIR_NONE;
        case (d)
            3'b001: begin
                if (e[1] && !e[0])       r = DIR_LATE;
                else if (e[2] && !e[1])  r = DIR_EARLY;
            end
            3'b011, 3'b100: begin
                if (!e[1] && e[0])       r = DIR_LATE;
                else if (!e[2] && e[1])  r = DIR_EARLY;
            end
            3'b110: begin
                if (e[1] && !e[0])                r = DIR_LATE;
                else if (e[2] && !e[1] && !e[0])  r = DIR_EARLY;
            end
            default: r = DIR_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mmpv_history.sv
// Symbol history for the phase detector.
// Keeps the last two data bits and error signs of the previous accepted
// word and presents an extended vector {current word, history} so that
// lane i sees its window at positions i..i+2. Also reports whether a word
// has been accepted since reset. Assumes LANES >= 2.
module mmpv_history #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [LANES-1:0]   in_data,
    input  logic [LANES-1:0]   in_err,
    output logic [LANES+1:0]   ext_data,
    output logic [LANES+1:0]   ext_err,
    output logic               primed
);
    localparam int HIST = 2;

    logic [HIST-1:0] hist_d;
    logic [HIST-1:0] hist_e;

    // Capture the newest two symbols of each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_d <= '0;
            hist_e <= '0;
            primed <= 1'b0;
        end else if (in_valid) begin
            hist_d <= in_data[LANES-1:LANES-HIST];
            hist_e <= in_err[LANES-1:LANES-HIST];
            primed <= 1'b1;
        end
    end

    // Join history below the current word: index 0 is the oldest symbol.
    always_comb begin
        ext_data = {in_data, hist_d};
        ext_err  = {in_err, hist_e};
    end

endmodule

// File: rtl/mmpv_lane_decode.sv
// One lane of pattern decode.
// Takes a three-symbol data window and error-sign window (bit 2 oldest)
// and returns the ternary timing direction. Purely combinational.
module mmpv_lane_decode
    import mmpv_pkg::*;
(
    input  logic [2:0] d_win,
    input  logic [2:0] e_win,
    output dir_e       dir
);
    // Look the window up in the shared pattern table.
    always_comb dir = classify(d_win, e_win);
endmodule

// File: rtl/mmpv_vote.sv
// Sign-of-sum vote over the per-lane ternary codes.
// Adds +1 per late lane and -1 per early lane and returns the sign of the
// total. Ties and all-none give none. Purely combinational.
module mmpv_vote
    import mmpv_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [2*LANES-1:0] codes,
    output dir_e               vote
);
    localparam int SUM_W = $clog2(LANES + 1) + 1;
    localparam logic signed [SUM_W-1:0] ONE  = SUM_W'(1);
    localparam logic signed [SUM_W-1:0] ZERO = '0;

    logic signed [SUM_W-1:0] acc;

    // Accumulate the signed lane contributions.
    always_comb begin
        acc = ZERO;
        for (int i = 0; i < LANES; i++) begin
            if (codes[2*i +: 2] == DIR_LATE)       acc = acc + ONE;
            else if (codes[2*i +: 2] == DIR_EARLY) acc = acc - ONE;
        end
    end

    // Reduce the total to its sign.
    always_comb begin
        if (acc > ZERO)      vote = DIR_LATE;
        else if (acc < ZERO) vote = DIR_EARLY;
        else                 vote = DIR_NONE;
    end
endmodule

// File: rtl/mm_phase_vote.sv
// Baud-rate sign-sampled phase detector with lane vote (top).
// Accepts a word of LANES data decisions and error signs per valid cycle,
// decodes each lane's three-symbol window and votes the lanes into one
// direction. Outputs are registered, one cycle after the accepted word.
// Results of the first word after reset are forced to none.
// Assumes LANES >= 2; reset is synchronous and active low.
module mm_phase_vote
    import mmpv_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [LANES-1:0]   in_data,
    input  logic [LANES-1:0]   in_err,
    output logic               out_valid,
    output logic [1:0]         out_vote,
    output logic [2*LANES-1:0] out_lane_dir
);
    localparam int EXT_W = LANES + 2;

    logic [EXT_W-1:0]   ext_data;
    logic [EXT_W-1:0]   ext_err;
    logic               primed;
    logic [2*LANES-1:0] lane_codes;
    dir_e               vote_c;

    mmpv_history #(.LANES(LANES)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_err   (in_err),
        .ext_data (ext_data),
        .ext_err  (ext_err),
        .primed   (primed)
    );

    // One decoder per lane, each on its own sliding window.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dir_e lane_dir;
        mmpv_lane_decode u_dec (
            .d_win ({ext_data[g], ext_data[g+1], ext_data[g+2]}),
            .e_win ({ext_err[g],  ext_err[g+1],  ext_err[g+2]}),
            .dir   (lane_dir)
        );
        assign lane_codes[2*g +: 2] = lane_dir;
    end

    mmpv_vote #(.LANES(LANES)) u_vote (
        .codes (lane_codes),
        .vote  (vote_c)
    );

    // Register results; zero them when idle or before history exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_vote     <= DIR_NONE;
            out_lane_dir <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && primed) begin
                out_vote     <= vote_c;
                out_lane_dir <= lane_codes;
            end else begin
                out_vote     <= DIR_NONE;
                out_lane_dir <= '0;
            end
        end
    end

endmodule

// File: rtl/mmpv_checker.sv
// Assertion checker for mm_phase_vote, attached with bind.
// Checks handshake timing, idle zeroing, lane code legality, vote
// consistency with the lane codes, and the forced-none first word.
module mmpv_checker #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [1:0]         out_vote,
    input logic [2*LANES-1:0] out_lane_dir
);
    int   late_n;
    int   early_n;
    logic bad_code;
    logic seen_word;

    // Count lane directions on the output and flag illegal codes.
    always_comb begin
        late_n   = 0;
        early_n  = 0;
        bad_code = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (out_lane_dir[2*i +: 2] == 2'b01) late_n++;
            if (out_lane_dir[2*i +: 2] == 2'b11) early_n++;
            if (out_lane_dir[2*i +: 2] == 2'b10) bad_code = 1'b1;
        end
    end

    // Remember whether a word has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_word <= 1'b0;
        else if (in_valid) seen_word <= 1'b1;
    end

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_vote == 2'b00 && out_lane_dir == '0));
    assert_lane_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code && out_vote != 2'b10);
    assert_vote_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vote == 2'b01) |-> (late_n > early_n));
    assert_vote_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vote == 2'b11) |-> (early_n > late_n));
    assert_vote_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vote == 2'b00) |-> (early_n == late_n));
    assert_first_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !seen_word) |=> (out_vote == 2'b00 && out_lane_dir == '0));

endmodule

bind mm_phase_vote mmpv_checker #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_vote     (out_vote),
    .out_lane_dir (out_lane_dir)
);

// File: tb/mm_phase_vote_tb.sv
// Self-checking bench for mm_phase_vote (LANES = 4, 250 MHz clock).
module mm_phase_vote_tb;
    localparam int LANES = 4;
    localparam int NV = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_data = '0;
    logic [3:0] in_err = '0;
    logic       out_valid;
    logic [1:0] out_vote;
    logic [7:0] out_lane_dir;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    mm_phase_vote #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_data(in_data), .in_err(in_err),
        .out_valid(out_valid), .out_vote(out_vote), .out_lane_dir(out_lane_dir)
    );

    // Entry: {prev data, prev err, cur data, cur err, lane codes, vote}.
    // Words written lane3..lane0; lane codes lane3 in bits 7:6.
    localparam logic [25:0] VEC [NV] = '{
        {4'b0000, 4'b1000, 4'b1111, 4'b0000, 8'h01, 2'b01}, // R1 late, lane 0
        {4'b0000, 4'b0100, 4'b1111, 4'b0000, 8'h03, 2'b11}, // R1 early, lane 0
        {4'b0100, 4'b0000, 4'b1111, 4'b0010, 8'h04, 2'b01}, // R2 late, lane 1
        {4'b0100, 4'b0000, 4'b1111, 4'b0001, 8'h0C, 2'b11}, // R2 early, lane 1
        {4'b0100, 4'b0000, 4'b0001, 4'b0100, 8'h10, 2'b01}, // R3 late, lane 2
        {4'b0100, 4'b0000, 4'b0001, 4'b0010, 8'h30, 2'b11}, // R3 early, lane 2
        {4'b1100, 4'b0000, 4'b0111, 4'b0100, 8'h40, 2'b01}, // R4 late, lane 3
        {4'b1100, 4'b0000, 4'b0111, 4'b0010, 8'hC0, 2'b11}, // R4 early, lane 3
        {4'b1100, 4'b0000, 4'b0111, 4'b1010, 8'h00, 2'b00}, // R4 current error 1: none
        {4'b1010, 4'b0110, 4'b1010, 4'b1001, 8'h00, 2'b00}, // R5 alternating data
        {4'b0000, 4'b0000, 4'b1111, 4'b0000, 8'h00, 2'b00}, // R5 errors fit no rule
        {4'b0000, 4'b0100, 4'b0111, 4'b0100, 8'h43, 2'b00}, // R7 tie, R8 lane 0 from history
        {4'b0000, 4'b1000, 4'b0111, 4'b0110, 8'h45, 2'b01}  // R7 three late lanes
    };
    localparam int TAG [NV] = '{1, 1, 2, 2, 3, 3, 4, 4, 4, 5, 5, 7, 7};

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] d, input logic [3:0] e);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_err   = e;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input logic [3:0] junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = junk;
        in_err   = ~junk;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        do_reset();
        // R9: reset state
        check("R9", "reset valid", {7'd0, out_valid}, 8'h00);
        check("R9", "reset vote", {6'd0, out_vote}, 8'h00);
        check("R9", "reset lanes", out_lane_dir, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: first word after reset would give lane 2 late; forced none
        send(4'b0001, 4'b0100);
        check("R9", "first word lanes", out_lane_dir, 8'h00);
        check("R9", "first word vote", {6'd0, out_vote}, 8'h00);
        check("R10", "valid after word", {7'd0, out_valid}, 8'h01);
        // R8: second word, lane 0 early from previous tail, lane 2 late
        send(4'b0001, 4'b0100);
        check("R8", "second word lanes", out_lane_dir, 8'h13);
        check("R7", "second word vote", {6'd0, out_vote}, 8'h00);

        // Table walk: R1..R7 pattern decode and vote
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][25:22], VEC[i][21:18]);
            send(VEC[i][17:14], VEC[i][13:10]);
            check($sformatf("R%0d", TAG[i]), $sformatf("row %0d lanes", i),
                  out_lane_dir, VEC[i][9:2]);
            check($sformatf("R%0d", TAG[i]), $sformatf("row %0d vote", i),
                  {6'd0, out_vote}, {6'd0, VEC[i][1:0]});
            check("R6", $sformatf("row %0d lane code 10 absent", i),
                  {7'd0, (out_lane_dir[1:0] == 2'b10) || (out_lane_dir[3:2] == 2'b10) ||
                         (out_lane_dir[5:4] == 2'b10) || (out_lane_dir[7:6] == 2'b10)},
                  8'h00);
        end

        // R10: idle cycles zero the outputs and leave history alone
        send(4'b0000, 4'b1000);
        idle(3, 4'b1111);
        check("R10", "idle valid", {7'd0, out_valid}, 8'h00);
        check("R10", "idle vote", {6'd0, out_vote}, 8'h00);
        check("R10", "idle lanes", out_lane_dir, 8'h00);
        send(4'b1111, 4'b0000);
        check("R10", "history kept over idle, lanes", out_lane_dir, 8'h01);
        check("R10", "history kept over idle, vote", {6'd0, out_vote}, 8'h01);
        idle(1, 4'b0000);
        check("R10", "valid drops one cycle later", {7'd0, out_valid}, 8'h00);

        // R9: reset mid-stream clears outputs and history
        send(4'b1100, 4'b0000);
        do_reset();
        check("R9", "mid-stream reset vote", {6'd0, out_vote}, 8'h00);
        check("R9", "mid-stream reset valid", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        send(4'b0111, 4'b0100);
        check("R9", "first word after second reset", out_lane_dir, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule